// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block turns single requests from a synchronous system bus into correctly timed read and write cycles on an external asynchronous static RAM of 131,072 words by 24 bits. The requester presents a 17-bit word address, 24-bit write data, a direction flag and a valid strobe. It holds them until the controller answers with a one-clock acknowledge. For a read, the captured word appears on the response data output in that same clock.

On the memory side the controller drives the address, two active-low enables and one active-high enable (the memory is selected only when both low enables are low and the high enable is high), an output enable, a write enable, and a 24-bit data bus split into an outgoing value, an incoming value and an output-enable for the pads. The length of each phase is a count of system clocks set by a parameter. The integrator picks these counts so that, at the chosen clock, the memory's access time, write pulse width and data setup minimums are met. The output enable stays high for every write, so the shorter write pulse minimum applies. Every write ends on the rising edge of write enable. Address, data and enables stay unchanged for one more clock after that edge, which covers the zero hold minimums. Between cycles the memory is deselected.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and after reset, with no request pending, the memory is deselected (both low enables at 1, high enable at 0), output enable and write enable are 1, the pad output-enable is 0 and the acknowledge is 0.
- R2: A read (request accepted with direction flag 0) holds the memory selected with output enable 0, write enable 1 and pad output-enable 0 for exactly RD_CYC clocks. The incoming data is captured at the clock edge that ends that phase and is presented on the response data output together with the acknowledge.
- R3: A write (direction flag 1) keeps output enable at 1 throughout. It drives write enable low for exactly WE_CYC consecutive clocks, and while write enable is low the memory is selected and the pad output-enable is 1.
- R4: In the clock in which write enable returns to 1, the address, outgoing data and selection keep the values they had while write enable was low.
- R5: Each accepted request produces exactly one acknowledge, which is high for a single clock.
- R6: The pad output-enable is never 1 while output enable is 0. In the clock before output enable goes to 0, the pad output-enable was already 0.
- R7: Between the end of one selected cycle and the start of the next, the memory stays deselected for at least REC_CYC clocks.
- R8: Address, write data and direction are sampled only in the clock a request is accepted from idle. Later changes on the request inputs do not alter the memory address or outgoing data of the cycle in progress.
- R9: RD_CYC, WE_CYC and REC_CYC must each be at least 1, and elaboration stops otherwise. At the intended clock, RD_CYC clocks cover a 9 ns access, WE_CYC clocks cover the 8 ns address-to-write-end minimum, and a write cycle covers 9 ns.
- R10: A read returns the most recent word written to that address, across all address bits and data patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 24 | Captured read word, valid with acknowledge of a read |
| mem_addr | output | 17 | Address to memory |
| mem_en0_n | output | 1 | First active-low memory enable |
| mem_en1_n | output | 1 | Second active-low memory enable |
| mem_en2 | output | 1 | Active-high memory enable |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 24 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 24 | Data returned from the memory pads |

## Verification
The main function is tried with reads of never-written words at address zero and all-ones, with single write-then-read pairs using all-zero, all-one and alternating-bit words, and with a run of back-to-back writes read back in reverse order. The all-ones and alternating patterns tell a stuck or swapped address or data bit from a correct one. The back-to-back run separates correct recovery and contention spacing from a design that reselects too early. Overwriting the same address shows that the latest write wins. Scrambling the request inputs right after acceptance tells apart a design that samples once from one that follows its inputs.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WSET = 3'd2,
      ST_WPUL = 3'd3,
      ST_WHLD = 3'd4,
      ST_REC  = 3'd5
   } ctl_st_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/sram_phase_tmr.sv
module sram_phase_tmr #(
   parameter int MAXC = 2,
   localparam int CW  = $clog2(MAXC) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   output logic          last
);

   generate
      if (MAXC == 1) begin : g_single
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, load, len};
         assign last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= len - CW'(1);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - CW'(1);
            end
         end
         assign last = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctl_pkg::*;
#(
   parameter int RD_CYC  = 2,
   parameter int WE_CYC  = 2,
   parameter int REC_CYC = 1,
   localparam int MAXC   = max3(RD_CYC, WE_CYC, REC_CYC),
   localparam int CW     = $clog2(MAXC) + 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_write,
   output ctl_st_e st_q,
   output ctl_st_e st_nxt,
   output logic    accept,
   output logic    cap_en,
   output logic    ack_set
);

   logic          tmr_load;
   logic [CW-1:0] tmr_len;
   logic          tmr_last;

   sram_phase_tmr #(.MAXC(MAXC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .len   (tmr_len),
      .last  (tmr_last)
   );

   always_comb begin
      st_nxt   = st_q;
      accept   = 1'b0;
      cap_en   = 1'b0;
      ack_set  = 1'b0;
      tmr_load = 1'b0;
      tmr_len  = CW'(RD_CYC);
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (req_write) begin
                  st_nxt = ST_WSET;
               end else begin
                  st_nxt   = ST_RD;
                  tmr_load = 1'b1;
                  tmr_len  = CW'(RD_CYC);
               end
            end
         end
         ST_RD: begin
            if (tmr_last) begin
               st_nxt   = ST_REC;
               cap_en   = 1'b1;
               ack_set  = 1'b1;
               tmr_load = 1'b1;
               tmr_len  = CW'(REC_CYC);
            end
         end
         ST_WSET: begin
            st_nxt   = ST_WPUL;
            tmr_load = 1'b1;
            tmr_len  = CW'(WE_CYC);
         end
         ST_WPUL: begin
            if (tmr_last) st_nxt = ST_WHLD;
         end
         ST_WHLD: begin
            st_nxt   = ST_REC;
            ack_set  = 1'b1;
            tmr_load = 1'b1;
            tmr_len  = CW'(REC_CYC);
         end
         ST_REC: begin
            if (tmr_last) st_nxt = ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nxt;
   end

   // R8: a new request is taken only from the idle state
   AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (st_q == ST_IDLE)) else $error("accept outside idle"); // R8

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
   import sram_ctl_pkg::*;
#(
   parameter int AW      = 17,
   parameter int DW      = 24,
   parameter int WE_CYC  = 2,
   parameter int REC_CYC = 1,
   localparam int WRW    = $clog2(WE_CYC + 2),
   localparam int DSW    = $clog2(REC_CYC + 1) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ctl_st_e       st_nxt,
   input  logic          accept,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_en0_n,
   output logic          mem_en1_n,
   output logic          mem_en2,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe
);

   logic nx_sel, nx_rd, nx_wpul, nx_wdrv;
   logic sel_q;

   always_comb begin
      nx_sel  = st_nxt inside {ST_RD, ST_WSET, ST_WPUL, ST_WHLD};
      nx_rd   = (st_nxt == ST_RD);
      nx_wpul = (st_nxt == ST_WPUL);
      nx_wdrv = st_nxt inside {ST_WSET, ST_WPUL, ST_WHLD};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         sel_q      <= 1'b0;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
      end else begin
         if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
         sel_q     <= nx_sel;
         mem_oe_n  <= ~nx_rd;
         mem_we_n  <= ~nx_wpul;
         mem_dq_oe <= nx_wdrv;
      end
   end

   assign mem_en0_n = ~sel_q;
   assign mem_en1_n = ~sel_q;
   assign mem_en2   = sel_q;

   // run-length trackers for the assertions below
   logic [WRW-1:0] we_run;
   logic [DSW-1:0] ds_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run <= '0;
         ds_run <= DSW'(REC_CYC);
      end else begin
         if (!mem_we_n) begin
            if (we_run != {WRW{1'b1}}) we_run <= we_run + WRW'(1);
         end else begin
            we_run <= '0;
         end
         if (!sel_q) begin
            if (ds_run < DSW'(REC_CYC)) ds_run <= ds_run + DSW'(1);
         end else begin
            ds_run <= '0;
         end
      end
   end

   AST_WE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (sel_q && mem_oe_n && mem_dq_oe)) else $error("write window"); // R3
   AST_WE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == WRW'(WE_CYC))) else $error("we length"); // R3
   AST_WE_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && sel_q)) else $error("end hold"); // R4
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n)) else $error("contention"); // R6
   AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe)) else $error("release order"); // R6
   AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_q) |-> (ds_run >= DSW'(REC_CYC))) else $error("recovery gap"); // R7

endmodule

// File: rtl/sram_rd_cap.sv
module sram_rd_cap #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic          ack_set,
   input  logic [DW-1:0] mem_dq_in,
   output logic [DW-1:0] rsp_rdata,
   output logic          req_ack
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         req_ack   <= 1'b0;
      end else begin
         if (cap_en) rsp_rdata <= mem_dq_in;
         req_ack <= ack_set;
      end
   end

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack) else $error("ack too long"); // R5

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctl_pkg::*;
#(
   parameter int AW      = 17,
   parameter int DW      = 24,
   parameter int RD_CYC  = 2,
   parameter int WE_CYC  = 2,
   parameter int REC_CYC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ack,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_en0_n,
   output logic          mem_en1_n,
   output logic          mem_en2,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);

   // R9: elaboration-time parameter checks
   generate
      if (RD_CYC < 1)  begin : g_bad_rd  $error("RD_CYC must be at least 1");  end
      if (WE_CYC < 1)  begin : g_bad_we  $error("WE_CYC must be at least 1");  end
      if (REC_CYC < 1) begin : g_bad_rec $error("REC_CYC must be at least 1"); end
      if (AW < 1 || DW < 1) begin : g_bad_w $error("widths must be positive"); end
   endgenerate

   ctl_st_e st_q, st_nxt;
   logic    accept, cap_en, ack_set;

   sram_seq_fsm #(
      .RD_CYC  (RD_CYC),
      .WE_CYC  (WE_CYC),
      .REC_CYC (REC_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .st_q      (st_q),
      .st_nxt    (st_nxt),
      .accept    (accept),
      .cap_en    (cap_en),
      .ack_set   (ack_set)
   );

   sram_pin_drv #(
      .AW      (AW),
      .DW      (DW),
      .WE_CYC  (WE_CYC),
      .REC_CYC (REC_CYC)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_nxt     (st_nxt),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_addr   (mem_addr),
      .mem_en0_n  (mem_en0_n),
      .mem_en1_n  (mem_en1_n),
      .mem_en2    (mem_en2),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   sram_rd_cap #(.DW(DW)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .ack_set   (ack_set),
      .mem_dq_in (mem_dq_in),
      .rsp_rdata (rsp_rdata),
      .req_ack   (req_ack)
   );

   // R1: the idle state leaves the memory deselected with no pad drive
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (mem_en0_n && mem_en1_n && !mem_en2 && mem_we_n
                             && mem_oe_n && !mem_dq_oe)) else $error("idle pins"); // R1

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_sram_cycle_ctrl;

   localparam int AW = 17, DW = 24;
   localparam int RDC = 2, WEC = 2, RCC = 1;
   localparam int TCK = 8;
   localparam logic [DW-1:0] FLOAT = 24'h5A5A5A;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ack;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_en0_n, mem_en1_n, mem_en2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = FLOAT;

   always #(TCK/2) clk = ~clk;

   sram_cycle_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RDC), .WE_CYC(WEC), .REC_CYC(RCC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_en0_n(mem_en0_n), .mem_en1_n(mem_en1_n), .mem_en2(mem_en2),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
      return {a[7:0] ^ 8'hC3, a[15:0]};
   endfunction

   // memory model: selected when both low enables low and high enable high
   logic [DW-1:0] model[int];
   wire sel = !mem_en0_n && !mem_en1_n && mem_en2;

   always @(negedge clk)
      mem_dq_in <= (sel && !mem_oe_n && mem_we_n)
                   ? (model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : init_word(mem_addr))
                   : FLOAT;

   always @(posedge mem_we_n)
      if (rst_n === 1'b1 && sel && mem_dq_oe) model[int'(mem_addr)] = mem_dq_out;

   // scoreboard
   typedef struct { bit rd; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
   item_t sbq[$];
   logic [DW-1:0] shadow[int];

   task automatic issue(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit scramble);
      item_t it;
      it.rd = rd; it.a = a;
      if (rd) it.d = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
      else begin it.d = d; shadow[int'(a)] = d; end
      sbq.push_back(it);
      @(negedge clk);
      req_valid = 1'b1; req_write = !rd; req_addr = a; req_wdata = d;
      if (scramble) begin
         @(negedge clk);
         req_addr = ~a; req_wdata = ~d; req_write = rd; // R8
      end
      do @(negedge clk); while (!req_ack);
      req_valid = 1'b0;
   endtask

   // monitor
   int we_run = 0, rd_run = 0, ds_run = 100;
   logic p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0, p_sel = 1'b0, p_ack = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_dout = '0;

   always @(negedge clk) if (rst_n) begin
      if (req_ack) begin
         chk(!p_ack, "R5 ack width", 32'(p_ack), 32'd0);
         if (sbq.size() == 0) chk(1'b0, "R5 unexpected ack", 32'd1, 32'd0);
         else begin
            item_t it;
            it = sbq.pop_front();
            if (it.rd) chk(rsp_rdata == it.d, "R2/R10 read data", 32'(rsp_rdata), 32'(it.d));
         end
      end
      if (!mem_we_n) begin
         chk(mem_oe_n && sel && mem_dq_oe, "R3 write window", {mem_oe_n, sel, mem_dq_oe}, 32'd7);
         we_run++;
      end
      if (mem_we_n && !p_we) begin
         chk(we_run == WEC, "R3 we length", 32'(we_run), 32'(WEC));
         chk(mem_addr == p_addr && mem_dq_out == p_dout && sel, "R4 end hold",
             32'(mem_addr), 32'(p_addr));
         if (sbq.size() > 0)
            chk(mem_addr == sbq[0].a && mem_dq_out == sbq[0].d, "R8 write fields",
                32'(mem_dq_out), 32'(sbq[0].d));
         we_run = 0;
      end
      if (!mem_oe_n) begin
         chk(!mem_dq_oe && sel && mem_we_n, "R6 read drive", 32'(mem_dq_oe), 32'd0);
         if (sbq.size() > 0) chk(mem_addr == sbq[0].a, "R8 read addr", 32'(mem_addr), 32'(sbq[0].a));
         if (p_oe) chk(!p_dqoe, "R6 release before oe", 32'(p_dqoe), 32'd0);
         rd_run++;
      end
      if (mem_oe_n && !p_oe) begin
         chk(rd_run == RDC, "R2 read length", 32'(rd_run), 32'(RDC));
         rd_run = 0;
      end
      if (sel && !p_sel) chk(ds_run >= RCC, "R7 recovery", 32'(ds_run), 32'(RCC));
      if (!sel) ds_run++; else ds_run = 0;
      p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe; p_sel = sel; p_ack = req_ack;
      p_addr = mem_addr; p_dout = mem_dq_out;
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(TCK * 150000);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      summary();
   end

   initial begin
      // R9: phase counts against timing minimums at this clock
      chk(RDC * TCK >= 9, "R9 read access", 32'(RDC * TCK), 32'd9);
      chk(WEC * TCK >= 8, "R9 write pulse", 32'(WEC * TCK), 32'd8);
      chk((WEC + 2) * TCK >= 9, "R9 write cycle", 32'((WEC + 2) * TCK), 32'd9);
      chk((WEC + 1) * TCK >= 5, "R9 data setup", 32'((WEC + 1) * TCK), 32'd5);
      repeat (3) @(negedge clk);
      chk(mem_en0_n && mem_en1_n && !mem_en2 && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack,
          "R1 in reset", {mem_en0_n, mem_en1_n, mem_en2, mem_oe_n, mem_we_n, mem_dq_oe, req_ack},
          32'b1101100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(mem_en0_n && mem_en1_n && !mem_en2 && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack,
          "R1 after reset", {mem_en0_n, mem_en1_n, mem_en2, mem_oe_n, mem_we_n, mem_dq_oe, req_ack},
          32'b1101100);

      issue(1'b1, 17'h00000, '0, 1'b0);               // R10 unwritten low
      issue(1'b1, 17'h1FFFF, '0, 1'b0);               // R10 unwritten high
      issue(1'b0, 17'h00005, 24'h123456, 1'b0);
      issue(1'b1, 17'h00005, '0, 1'b0);
      issue(1'b0, 17'h1FFFF, 24'hFFFFFF, 1'b0);
      issue(1'b1, 17'h1FFFF, '0, 1'b0);
      issue(1'b0, 17'h00000, 24'h000000, 1'b0);
      issue(1'b1, 17'h00000, '0, 1'b0);
      issue(1'b0, 17'h0AAAA, 24'h555555, 1'b1);       // R8 scrambled inputs
      issue(1'b1, 17'h0AAAA, '0, 1'b1);
      issue(1'b1, 17'h15555, '0, 1'b0);               // R8 complement untouched
      for (int i = 0; i < 8; i++)
         issue(1'b0, AW'(17'h10000 + (i << 4)), 24'hA00000 | DW'(i * 24'h1111), 1'b0);
      for (int i = 7; i >= 0; i--)
         issue(1'b1, AW'(17'h10000 + (i << 4)), '0, 1'b0);
      issue(1'b0, 17'h00033, 24'hAAAAAA, 1'b0);
      issue(1'b0, 17'h00033, 24'h555555, 1'b0);        // R10 latest wins
      issue(1'b1, 17'h00033, '0, 1'b0);
      repeat (4) @(negedge clk);
      chk(sbq.size() == 0, "R5 all acknowledged", 32'(sbq.size()), 32'd0);
      chk(mem_en0_n && !mem_en2 && !mem_dq_oe, "R1 idle at end", {mem_en0_n, mem_en2, mem_dq_oe}, 32'b100);
      summary();
   end

endmodule